// File: doc/BRIEF.md
# Triggered Programmable Pulse Timer

This block produces a single pulse whose length is set by a reload value. Software starts the pulse by writing a start bit. When enabled, a falling edge on one of two external restart lines can also start it. The pulse ends when an up-counter wraps past all ones. It also ends when software clears the start bit or, when enabled, when a falling edge arrives on one of two external stop lines. The output is high for as long as the counter runs.

All four trigger lines are asynchronous digital levels. Each passes through a synchronizer, and only a falling edge counts as a trigger. The counter advances only on cycles where the fixed-rate clock enable is high. While the pulse is running, any further start request is discarded, so the pulse cannot be stretched.

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset the pulse output is low and the read word is 0: both trigger enables clear, timer stopped.
- R2: A register write with bit 0 (start) = 1 while stopped loads the counter with `reloadVal` and raises the output. The counter then steps by one on every cycle where `tickEn` is high. With `tickEn` held high, the output stays high for 2^CNT_W − reload cycles.
- R3: When the counter holds all ones and `tickEn` is high, the timer stops on that edge and the start bit reads 0.
- R4: A register write with bit 0 = 0 stops the timer on the write edge.
- R5: With stop-enable (write bit 1) = 1, a falling edge on `stopSrcA` or `stopSrcB` stops the timer. The line is driven low before edge k, and the output is low after edge k+2.
- R6: With stop-enable = 0, the stop lines have no effect.
- R7: With restart-enable (write bit 2) = 1, a falling edge on `restartSrcA` or `restartSrcB` starts a stopped timer with the same timing as R5, loading `reloadVal` as in R2.
- R8: With restart-enable = 0, the restart lines have no effect.
- R9: While running, a restart falling edge or a write with bit 0 = 1 changes neither the pulse nor its end time.
- R10: If a stop request and a start request are taken on the same edge, the stop wins and the timer ends stopped.
- R11: Every write updates all three bits. Read word bit 0 is the pulse output, bit 1 is stop-enable and bit 2 is restart-enable. The triggers are gated by the enable values held before the write edge.
- R12: Rising edges on any trigger line have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| tickEn | input | 1 | counter clock enable |
| regWr | input | 1 | register write strobe |
| regWdata | input | 3 | write word {restartEn, stopEn, start} |
| regRdata | output | 3 | read word {restartEn, stopEn, pulse} |
| reloadVal | input | CNT_W | counter start value |
| stopSrcA | input | 1 | stop trigger line A |
| stopSrcB | input | 1 | stop trigger line B |
| restartSrcA | input | 1 | restart trigger line A |
| restartSrcB | input | 1 | restart trigger line B |
| pulseOut | output | 1 | high while the timer runs |

## Verification
The bench checks the stop-over-start tie on one edge. A design that honoured the restart would leave the output high when it should drop. It measures pulse width while restart edges and start writes hit a running timer. A design that reloaded on them would stretch the pulse past 2^CNT_W − reload cycles. Trigger latency is checked on exact edges, so a missing or extra synchronizer stage shows up as an output that changes one cycle off. Rising edges and triggers on disabled lines are checked for leaving the output untouched. A long seeded random run is compared cycle by cycle against a reference model, which catches wrong enable gating and an overflow test that ignores `tickEn`.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef struct packed {
    logic restartEn;
    logic stopEn;
    logic start;
  } regWord_t;

  typedef struct packed {
    logic load;
    logic count;
  } dpStrobe_t;

  localparam int NUM_STOP = 2;
  localparam int NUM_RESTART = 2;
  localparam int NUM_TRIG = NUM_STOP + NUM_RESTART;
endpackage

// File: rtl/ptmr_edge.sv
module ptmr_edge #(
  parameter int N = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      logic [SYNC_STAGES-1:0] syncChain;
      logic prevLvl;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncChain <= '0;
          prevLvl <= 1'b0;
        end else begin
          syncChain <= {syncChain[SYNC_STAGES-2:0], lvl[i]};
          prevLvl <= syncChain[SYNC_STAGES-1];
        end
      end
      assign fall[i] = prevLvl & ~syncChain[SYNC_STAGES-1];

      assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rstN)
        fall[i] |=> !fall[i]);
    end
  endgenerate
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic                   regWr,
  input  regWord_t               regWdata,
  input  logic [NUM_STOP-1:0]    stopFall,
  input  logic [NUM_RESTART-1:0] restartFall,
  input  logic                   atMax,
  output logic                   running,
  output logic                   stopEn,
  output logic                   restartEn,
  output dpStrobe_t              strobe
);
  logic swStop, swStart, hwStop, hwStart, stopReq, startReq, ovf;

  assign swStop   = regWr & ~regWdata.start;
  assign swStart  = regWr & regWdata.start;
  assign hwStop   = stopEn & (|stopFall);
  assign hwStart  = restartEn & (|restartFall);
  assign stopReq  = swStop | hwStop;
  assign ovf      = running & tickEn & atMax;
  assign startReq = ~running & ~stopReq & (swStart | hwStart);

  always_comb begin
    strobe.load  = startReq;
    strobe.count = running & tickEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      stopEn <= 1'b0;
      restartEn <= 1'b0;
    end else begin
      if (stopReq || ovf) running <= 1'b0;
      else if (startReq) running <= 1'b1;
      if (regWr) begin
        stopEn <= regWdata.stopEn;
        restartEn <= regWdata.restartEn;
      end
    end
  end

  assert_ovf_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && atMax) |=> !running);
  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regWdata.start) |=> !running);
  assert_stop_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stopEn && (|stopFall)) |=> !running);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (running && !(tickEn && atMax) && !(regWr && !regWdata.start)
     && !(stopEn && (|stopFall))) |=> running);
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             atMax
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strobe.load) cnt <= reloadVal;
    else if (strobe.count) cnt <= cnt + 1'b1;
  end

  assign atMax = (cnt == CNT_MAX);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> cnt == $past(reloadVal));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.count) |=> $stable(cnt));
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             regWr,
  input  logic [2:0]       regWdata,
  output logic [2:0]       regRdata,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             stopSrcA,
  input  logic             stopSrcB,
  input  logic             restartSrcA,
  input  logic             restartSrcB,
  output logic             pulseOut
);
  logic [NUM_TRIG-1:0] trigLvl, trigFall;
  logic running, stopEn, restartEn, atMax;
  dpStrobe_t strobe;
  regWord_t wrWord;

  assign trigLvl = {restartSrcB, restartSrcA, stopSrcB, stopSrcA};
  assign wrWord = regWord_t'(regWdata);

  ptmr_edge #(.N(NUM_TRIG), .SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .lvl(trigLvl), .fall(trigFall));

  ptmr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regWdata(wrWord),
    .stopFall(trigFall[NUM_STOP-1:0]),
    .restartFall(trigFall[NUM_TRIG-1:NUM_STOP]),
    .atMax(atMax), .running(running), .stopEn(stopEn),
    .restartEn(restartEn), .strobe(strobe));

  ptmr_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal), .atMax(atMax));

  assign pulseOut = running;
  assign regRdata = {restartEn, stopEn, running};
endmodule

// File: tb/trig_pulse_timer_test.sv
module trig_pulse_timer_test;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rstN = 0, tickEn = 1, regWr = 0;
  logic [2:0] regWdata = 0;
  logic [2:0] regRdata;
  logic [W-1:0] reloadVal = 0;
  logic stopSrcA = 1, stopSrcB = 1, restartSrcA = 1, restartSrcB = 1;
  logic pulseOut;

  int checks = 0, fails = 0;
  bit cmpOn = 0, done = 0;

  trig_pulse_timer #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .reloadVal(reloadVal), .stopSrcA(stopSrcA),
    .stopSrcB(stopSrcB), .restartSrcA(restartSrcA), .restartSrcB(restartSrcB),
    .pulseOut(pulseOut));

  always #5 clk = ~clk;

  // reference model built from the requirements
  logic [3:0] mS1, mS2, mPrev;
  logic mRun, mStopEn, mRstEn;
  int mCnt;

  function automatic logic fallOf(logic [3:0] p, logic [3:0] c, int a, int b);
    return (p[a] & ~c[a]) | (p[b] & ~c[b]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mPrev <= 0; mRun <= 0; mStopEn <= 0; mRstEn <= 0; mCnt <= 0;
    end else begin
      logic stopR, startR, ovf;
      stopR = (regWr & ~regWdata[0]) | (mStopEn & fallOf(mPrev, mS2, 0, 1));
      ovf = mRun & tickEn & (mCnt == MAXV);
      startR = ~mRun & ~stopR & ((regWr & regWdata[0]) | (mRstEn & fallOf(mPrev, mS2, 2, 3)));
      if (stopR || ovf) mRun <= 0;
      else if (startR) mRun <= 1;
      if (startR) mCnt <= reloadVal;
      else if (mRun && tickEn) mCnt <= (mCnt + 1) & MAXV;
      if (regWr) begin mStopEn <= regWdata[1]; mRstEn <= regWdata[2]; end
      mPrev <= mS2; mS2 <= mS1;
      mS1 <= {restartSrcB, restartSrcA, stopSrcB, stopSrcA};
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn) begin
    check("R2,R3,R5,R7 model pulse", pulseOut, mRun);
    check("R11 model read word", regRdata, {mRstEn, mStopEn, mRun});
  end

  task automatic wrReg(logic [2:0] d);
    regWr = 1; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    idle(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pulse after reset", pulseOut, 0);
    check("R1 read word after reset", regRdata, 0);

    // R2/R3 pulse width 2^W - reload
    reloadVal = 250;
    wrReg(3'b001);
    n = 0;
    while (pulseOut && n < 400) begin n++; @(negedge clk); end
    check("R2 width reload 250", n, 6);
    check("R3 start bit cleared by overflow", regRdata[0], 0);
    reloadVal = 255;
    wrReg(3'b001);
    n = 0;
    while (pulseOut && n < 400) begin n++; @(negedge clk); end
    check("R2 width reload max", n, 1);

    // R4 software clear
    reloadVal = 0;
    wrReg(3'b001);
    idle(3);
    wrReg(3'b000);
    check("R4 software stop", pulseOut, 0);

    // R11 field layout
    wrReg(3'b110);
    check("R11 enables read back", regRdata, 3'b110);

    // R5 stop line A, exact latency
    wrReg(3'b011);
    stopSrcA = 0;
    @(negedge clk); check("R5 still high after one edge", pulseOut, 1);
    @(negedge clk); check("R5 still high after two edges", pulseOut, 1);
    @(negedge clk); check("R5 stopped after three edges", pulseOut, 0);
    stopSrcA = 1;
    idle(4);
    check("R12 rising stop edge ignored", pulseOut, 0);

    // R6 stop lines ignored when disabled
    wrReg(3'b001);
    stopSrcB = 0;
    idle(6);
    check("R6 disabled stop ignored", pulseOut, 1);
    stopSrcB = 1;
    wrReg(3'b000);

    // R8 restart ignored when disabled
    idle(3);
    restartSrcB = 0;
    idle(6);
    check("R8 disabled restart ignored", pulseOut, 0);
    restartSrcB = 1;
    idle(4);

    // R7 restart line A starts timer
    wrReg(3'b100);
    restartSrcA = 0;
    @(negedge clk); @(negedge clk);
    check("R7 not yet started", pulseOut, 0);
    @(negedge clk);
    check("R7 restart started", pulseOut, 1);
    restartSrcA = 1;
    wrReg(3'b100);
    idle(4);
    check("R12 rising restart edge ignored", pulseOut, 0);

    // R9 start requests while running change nothing
    reloadVal = 200;
    wrReg(3'b101);
    n = 0;
    while (pulseOut && n < 400) begin
      n++;
      if (n == 10) restartSrcA = 0;
      if (n == 12) begin regWr = 1; regWdata = 3'b101; end
      if (n == 13) regWr = 0;
      if (n == 20) restartSrcB = 0;
      @(negedge clk);
    end
    restartSrcA = 1; restartSrcB = 1;
    check("R9 width unchanged by restart", n, 56);
    idle(4);

    // R10 stop beats restart on the same edge (stopped timer)
    wrReg(3'b110);
    stopSrcA = 0; restartSrcA = 0;
    idle(5);
    check("R10 stop wins while stopped", pulseOut, 0);
    stopSrcA = 1; restartSrcA = 1;
    idle(4);
    // R10 while running with a concurrent start write
    reloadVal = 0;
    wrReg(3'b111);
    stopSrcB = 0;
    @(negedge clk); @(negedge clk);
    regWr = 1; regWdata = 3'b111;
    @(negedge clk);
    regWr = 0;
    check("R10 stop wins over start write", pulseOut, 0);
    stopSrcB = 1;
    idle(4);

    // random phase against model
    cmpOn = 1;
    for (int c = 0; c < 20000; c++) begin
      tickEn = ($urandom % 4) != 0;
      regWr = ($urandom % 24) == 0;
      regWdata = 3'($urandom);
      reloadVal = W'(192 + ($urandom % 64));
      if ($urandom % 20 == 0) stopSrcA = ~stopSrcA;
      if ($urandom % 23 == 0) stopSrcB = ~stopSrcB;
      if ($urandom % 9 == 0) restartSrcA = ~restartSrcA;
      if ($urandom % 11 == 0) restartSrcB = ~restartSrcB;
      @(negedge clk);
    end
    cmpOn = 0;
    finishRun();
  end
endmodule